// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block drives the command pins of an SDRAM device through its power-up setup. A single-cycle start request, taken while the block is idle, launches a fixed series of four commands: one precharge of every bank, two auto-refresh commands, and a final load of the device mode register. Between the commands the block holds the bus at no-operation for a programmable number of clock cycles, so that the device's recovery times are met.

The mode word and the five wait lengths are sampled in the same clock edge that accepts the start request. They are held internally until the series ends, so the surrounding logic may change its inputs freely once the block reports busy. The data bus is never driven. When the last wait has elapsed, a one-cycle done pulse is raised and the block returns to idle with the chip deselected.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, busy=0, done=0, the command pins {cs_n,ras_n,cas_n,we_n}=1111 (deselect), and addr=0.
- R2: A start accepted at a clock edge puts the precharge-all command {cs_n,ras_n,cas_n,we_n}=0010 on the pins in the following cycle. It is followed in order by auto-refresh 0001, a second auto-refresh 0001, and mode-register load 0000. Every cycle between them carries no-op 0111.
- R3: Every command occupies exactly one clock cycle and is always followed by a no-op cycle.
- R4: Each wait field is 3 bits wide, and a field value v yields a phase of v+1 cycles. After precharge-all comes the wait_pre phase. After each auto-refresh come the wait_rr phase and then the wait_rc phase. After the mode-register load come the wait_mw phase and then the wait_nop phase.
- R5: During precharge-all, addr bit 11 (the bit wired to the device's A10) is 1 and all other address bits are 0.
- R6: During the mode-register load, addr[10:0] equals the sampled mode word and the upper address bits are 0. In every no-op, deselect and refresh cycle, addr is 0.
- R7: dq_oe stays 0 in every cycle, so the data bus remains high-impedance.
- R8: busy is 1 from the precharge-all cycle through the last wait_nop cycle. done is 1 for exactly the one cycle after that, with busy=0 and the pins at deselect, and is 0 again in the next cycle.
- R9: A start request while busy is ignored. Changes to mode_val or to the wait fields after acceptance have no effect on the running series.
- R10: While idle, the pins hold deselect (cs_n=1) and addr=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the series; accepted only when idle |
| mode_val | input | MODE_W | Word loaded into the device mode register |
| wait_pre | input | WAIT_W | Wait after precharge-all, cycles minus one |
| wait_rr | input | WAIT_W | First wait after each auto-refresh, cycles minus one |
| wait_rc | input | WAIT_W | Second wait after each auto-refresh, cycles minus one |
| wait_mw | input | WAIT_W | First wait after mode-register load, cycles minus one |
| wait_nop | input | WAIT_W | Final no-op wait, cycles minus one |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| dq_oe | output | 1 | Data bus output enable (always 0) |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle pulse after the series ends |

## Verification
The bench builds the block with its defaults: a 14-bit address, an 11-bit mode word, the A10 line on address bit 11 and 3-bit wait fields. With 3-bit fields, every legal length of each of the five waits (1 to 8 cycles) is swept one field at a time, and all five fields are also run at equal values. This covers both the shortest series and the longest. For each run, the bench compares the pins against an expected series that it builds from the field values, cycle by cycle. In half of the runs it fires start and rewrites all the inputs in mid-series, to show that the running series ignores them.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_PALL, PH_WPRE, PH_REF, PH_WRR,
    PH_WRC,  PH_MRS,  PH_WMW,  PH_WNOP, PH_DONE
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_DESEL = 4'b1111;
  localparam cmd_t CMD_NOP   = 4'b0111;
  localparam cmd_t CMD_PALL  = 4'b0010;
  localparam cmd_t CMD_REF   = 4'b0001;
  localparam cmd_t CMD_MRS   = 4'b0000;

  function automatic logic is_wait(phase_e p);
    return (p == PH_WPRE) || (p == PH_WRR) || (p == PH_WRC) ||
           (p == PH_WMW)  || (p == PH_WNOP);
  endfunction

  function automatic cmd_t phase_cmd(phase_e p);
    case (p)
      PH_PALL: return CMD_PALL;
      PH_REF:  return CMD_REF;
      PH_MRS:  return CMD_MRS;
      PH_WPRE, PH_WRR, PH_WRC, PH_WMW, PH_WNOP: return CMD_NOP;
      default: return CMD_DESEL;
    endcase
  endfunction

  // A field value v gives a phase of v+1 cycles.
  function automatic int unsigned phase_cycles(int unsigned field);
    return field + 1;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tmr_expired,
  input  logic [WAIT_W-1:0] w_pre,
  input  logic [WAIT_W-1:0] w_rr,
  input  logic [WAIT_W-1:0] w_rc,
  input  logic [WAIT_W-1:0] w_mw,
  input  logic [WAIT_W-1:0] w_nop,
  output phase_e            phase_q,
  output logic              tmr_load,
  output logic [WAIT_W-1:0] tmr_val
);

  phase_e phase_nxt;
  logic   second_q;
  logic   second_nxt;

  always_comb begin
    phase_nxt  = phase_q;
    second_nxt = second_q;
    case (phase_q)
      PH_IDLE: if (go) begin
        phase_nxt  = PH_PALL;
        second_nxt = 1'b0;
      end
      PH_PALL: phase_nxt = PH_WPRE;
      PH_WPRE: if (tmr_expired) phase_nxt = PH_REF;
      PH_REF:  phase_nxt = PH_WRR;
      PH_WRR:  if (tmr_expired) phase_nxt = PH_WRC;
      PH_WRC:  if (tmr_expired) begin
        if (second_q) begin
          phase_nxt = PH_MRS;
        end else begin
          phase_nxt  = PH_REF;
          second_nxt = 1'b1;
        end
      end
      PH_MRS:  phase_nxt = PH_WMW;
      PH_WMW:  if (tmr_expired) phase_nxt = PH_WNOP;
      PH_WNOP: if (tmr_expired) phase_nxt = PH_DONE;
      PH_DONE: phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (phase_nxt)
      PH_WPRE: tmr_val = w_pre;
      PH_WRR:  tmr_val = w_rr;
      PH_WRC:  tmr_val = w_rc;
      PH_WMW:  tmr_val = w_mw;
      PH_WNOP: tmr_val = w_nop;
      default: tmr_val = '0;
    endcase
  end

  assign tmr_load = is_wait(phase_nxt) && (phase_nxt != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      second_q <= 1'b0;
    end else begin
      phase_q  <= phase_nxt;
      second_q <= second_nxt;
    end
  end

endmodule

// File: rtl/sdram_init_cmdgen.sv
module sdram_init_cmdgen
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int MODE_W  = 11,
  parameter int A10_BIT = 11
) (
  input  phase_e            phase,
  input  logic [MODE_W-1:0] mode,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  cmd_t cmd;

  assign cmd   = phase_cmd(phase);
  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

  always_comb begin
    addr = '0;
    if (phase == PH_PALL) begin
      addr[A10_BIT] = 1'b1;
    end else if (phase == PH_MRS) begin
      addr[MODE_W-1:0] = mode;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int MODE_W  = 11,
  parameter int WAIT_W  = 3,
  parameter int A10_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_val,
  input  logic [WAIT_W-1:0] wait_pre,
  input  logic [WAIT_W-1:0] wait_rr,
  input  logic [WAIT_W-1:0] wait_rc,
  input  logic [WAIT_W-1:0] wait_mw,
  input  logic [WAIT_W-1:0] wait_nop,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic              busy,
  output logic              done
);

  phase_e            phase_q;
  logic              accept;
  logic              tmr_load;
  logic              tmr_expired;
  logic [WAIT_W-1:0] tmr_val;
  logic [MODE_W-1:0] mode_q;
  logic [WAIT_W-1:0] pre_q, rr_q, rc_q, mw_q, nop_q;

  assign accept = start && (phase_q == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pre_q  <= '0;
      rr_q   <= '0;
      rc_q   <= '0;
      mw_q   <= '0;
      nop_q  <= '0;
    end else if (accept) begin
      mode_q <= mode_val;
      pre_q  <= wait_pre;
      rr_q   <= wait_rr;
      rc_q   <= wait_rc;
      mw_q   <= wait_mw;
      nop_q  <= wait_nop;
    end
  end

  sdram_init_fsm #(.WAIT_W(WAIT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (accept),
    .tmr_expired (tmr_expired),
    .w_pre       (pre_q),
    .w_rr        (rr_q),
    .w_rc        (rc_q),
    .w_mw        (mw_q),
    .w_nop       (nop_q),
    .phase_q     (phase_q),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  sdram_init_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_init_cmdgen #(
    .ADDR_W  (ADDR_W),
    .MODE_W  (MODE_W),
    .A10_BIT (A10_BIT)
  ) u_cmdgen (
    .phase (phase_q),
    .mode  (mode_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr)
  );

  assign dq_oe = 1'b0;
  assign busy  = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign done  = (phase_q == PH_DONE);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W  = 14,
  parameter int MODE_W  = 11,
  parameter int A10_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic [MODE_W-1:0] mode_q
);

  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  // R5
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> addr[A10_BIT]);

  // R6
  mrs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (addr[MODE_W-1:0] == mode_q));

  // R3
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !(ras_n && cas_n && we_n)) |=> (pins == 4'b0111));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));

  // R10
  idle_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (cs_n && addr == '0));

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W  (ADDR_W),
  .MODE_W  (MODE_W),
  .A10_BIT (A10_BIT)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .cs_n   (cs_n),
  .ras_n  (ras_n),
  .cas_n  (cas_n),
  .we_n   (we_n),
  .addr   (addr),
  .busy   (busy),
  .done   (done),
  .mode_q (mode_q)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int ADDR_W  = 14;
  localparam int MODE_W  = 11;
  localparam int WAIT_W  = 3;
  localparam int A10_BIT = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [MODE_W-1:0] mode_val = '0;
  logic [WAIT_W-1:0] wait_pre = '0, wait_rr = '0, wait_rc = '0, wait_mw = '0, wait_nop = '0;
  logic cs_n, ras_n, cas_n, we_n, dq_oe, busy, done;
  logic [ADDR_W-1:0] addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .WAIT_W(WAIT_W), .A10_BIT(A10_BIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_val(mode_val),
    .wait_pre(wait_pre), .wait_rr(wait_rr), .wait_rc(wait_rc),
    .wait_mw(wait_mw), .wait_nop(wait_nop),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_oe(dq_oe), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  int step_k;
  bit disturb_on;

  // Compare n cycles of the pins against one expected pattern, then move on.
  task automatic emit(input logic [3:0] c, input int n, input logic [ADDR_W-1:0] a,
                      input logic exp_busy, input logic exp_done, input string tag);
    for (int i = 0; i < n; i++) begin
      check({tag, " pins"}, 32'({cs_n, ras_n, cas_n, we_n}), 32'(c));
      check({tag, " addr R5/R6"}, 32'(addr), 32'(a));
      check("R7 dq_oe", 32'(dq_oe), 32'd0);
      check("R8 busy", 32'(busy), 32'(exp_busy));
      check("R8 done", 32'(done), 32'(exp_done));
      // R9: start and new inputs in mid-series must change nothing
      if (disturb_on && step_k == 2) begin
        start = 1'b1;
        mode_val = ~mode_val;
        wait_pre = 3'd7; wait_rr = 3'd7; wait_rc = 3'd7; wait_mw = 3'd7; wait_nop = 3'd7;
      end else begin
        start = 1'b0;
      end
      step_k = step_k + 1;
      @(negedge clk);
    end
  endtask

  task automatic run(input int p, input int rr, input int rc, input int mw, input int nop,
                     input logic [MODE_W-1:0] m, input bit disturb);
    logic [ADDR_W-1:0] a_pall;
    logic [ADDR_W-1:0] a_mrs;
    a_pall = '0;
    a_pall[A10_BIT] = 1'b1;
    a_mrs = ADDR_W'(m);
    mode_val = m;
    wait_pre = WAIT_W'(p); wait_rr = WAIT_W'(rr); wait_rc = WAIT_W'(rc);
    wait_mw = WAIT_W'(mw); wait_nop = WAIT_W'(nop);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step_k = 0;
    disturb_on = disturb;
    // R2/R3: each command lasts one cycle; R4: wait v lasts v+1 cycles
    emit(4'b0010, 1, a_pall, 1'b1, 1'b0, "R2/R3 precharge-all");
    emit(4'b0111, p + 1, '0, 1'b1, 1'b0, "R4 wait_pre");
    for (int r = 0; r < 2; r++) begin
      emit(4'b0001, 1, '0, 1'b1, 1'b0, "R2/R3 refresh");
      emit(4'b0111, (rr + 1) + (rc + 1), '0, 1'b1, 1'b0, "R4 wait_rr+wait_rc");
    end
    emit(4'b0000, 1, a_mrs, 1'b1, 1'b0, "R2/R6 mode load");
    emit(4'b0111, (mw + 1) + (nop + 1), '0, 1'b1, 1'b0, "R4 wait_mw+wait_nop");
    emit(4'b1111, 1, '0, 1'b0, 1'b1, "R8 done cycle");
    emit(4'b1111, 1, '0, 1'b0, 1'b0, "R10 idle after");
  endtask

  initial begin
    disturb_on = 1'b0;
    step_k = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
    check("R1 addr", 32'(addr), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    // R10 idle holds deselect while inputs move without start
    for (int i = 0; i < 4; i++) begin
      mode_val = MODE_W'(i * 311);
      wait_pre = WAIT_W'(i);
      @(negedge clk);
      check("R10 idle pins", 32'({cs_n, ras_n, cas_n, we_n}), 32'hF);
      check("R10 idle addr", 32'(addr), 32'd0);
      check("R10 idle busy", 32'(busy), 32'd0);
    end
    // Sweep each field over all eight lengths, others fixed at 1
    for (int f = 0; f < 5; f++) begin
      for (int v = 0; v < 8; v++) begin
        run(f == 0 ? v : 1, f == 1 ? v : 1, f == 2 ? v : 1,
            f == 3 ? v : 1, f == 4 ? v : 1,
            MODE_W'((v * 37 + f * 401 + 5) & ((1 << MODE_W) - 1)), v[0]);
      end
    end
    // All fields equal, from shortest to longest series
    for (int v = 0; v < 8; v++) begin
      run(v, v, v, v, v, MODE_W'(v * 255 + 1), ~v[0]);
    end
    run(7, 0, 7, 0, 7, '1, 1'b1);
    run(0, 7, 0, 7, 0, '0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule